// File: doc/BRIEF.md
# Segment Access Protection Checker

This block checks one memory access against the cached fields of a protected-mode segment descriptor and forms the linear address of that access. For each request it takes the descriptor's base, limit, granularity flag, present flag, privilege level and type bits, together with the access offset, its length, its kind (read, write or instruction fetch) and the requesting privilege level. It returns the linear address, a fault flag and the interrupt type number to raise.

A request is accepted with a valid/ready handshake, and the result appears in a register one cycle later behind its own valid/ready pair. A result that is not taken holds its value and blocks new requests until it is taken. Faults are ranked, and only the first one found is reported: missing segment first, then privilege, then access type, then bounds. The linear address is always produced, even when the access faults.

Top module: `segAccessCheck`

## Requirements
- R1: A request is taken on a clock edge where inValid and inReady are both high; its result is shown with outValid high from the next cycle. inReady is high whenever outValid is low or outReady is high. While outValid is high and outReady is low, outValid stays high and linAddr, fault and faultType do not change.
- R2: linAddr equals descBase plus accOffset, modulo 2^32, for every access, faulting or not.
- R3: With descGran low the effective limit is descLimit in bytes. With descGran high it is descLimit shifted left by 12 with the low 12 bits set to one. The limit names the last valid byte.
- R4: accSize holds the byte count minus one (0 means 1 byte, 3 means 4 bytes). The last byte touched is accOffset plus accSize, formed with 33 bits. In an expand-up segment the access faults with type 13 when that last byte is above the effective limit, and this includes a carry past 2^32.
- R5: A data segment (descExec low) with descDir high expands downward. An access to it is legal only when accOffset is above the effective limit and the last byte does not carry past 2^32. Any other access faults with type 13.
- R6: With descPresent low, every access faults with type 11, and this fault outranks all others.
- R7: Level 0 is the most privileged. An access whose accRpl is numerically greater than descDpl faults with type 13. An equal level is allowed.
- R8: accKind is coded 0 read, 1 write, 2 fetch, and 3 acts as read. Each of these faults with type 13: a write to a code segment, whatever descRw says; a write to a data segment with descRw low; a read from a code segment with descRw low; a fetch from a data segment; and any access through a descriptor with descSeg low.
- R9: When no fault is found, fault is low and faultType is 0. When a fault is found, fault is high and faultType is 11 or 13.
- R10: During and straight after reset, outValid and fault are low and inReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request present |
| inReady | output | 1 | Request can be taken |
| descBase | input | 32 | Segment base address |
| descLimit | input | 20 | Segment limit field |
| descGran | input | 1 | Limit counted in 4K-byte units when high |
| descPresent | input | 1 | Segment is present |
| descDpl | input | 2 | Descriptor privilege level |
| descSeg | input | 1 | Code/data descriptor when high, system descriptor when low |
| descExec | input | 1 | Code segment when high, data segment when low |
| descDir | input | 1 | For data segments, expands downward when high |
| descRw | input | 1 | Data: writable; code: readable |
| accOffset | input | 32 | Offset inside the segment |
| accSize | input | 2 | Access length in bytes minus one |
| accKind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| accRpl | input | 2 | Requesting privilege level |
| outValid | output | 1 | Result present |
| outReady | input | 1 | Result is taken |
| linAddr | output | 32 | Linear address |
| fault | output | 1 | Access violates protection |
| faultType | output | 8 | Interrupt type number, 0 when there is no fault |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 20-bit limit, a 2-bit size field and type numbers 11 and 13. With these values the 4K-byte granularity step and the 33-bit carry out of a 4-byte access at offset FFFFFFFEh can both be reached with ordinary vectors. The expand-down, code-segment and privilege cases, and the ranking of a missing segment above a privilege violation, are each driven by their own vectors. A stall of several cycles with a competing request held on the input shows that a result is not overwritten before it is taken.

// File: rtl/segchk_pkg.sv
package segchk_pkg;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_RSVD  = 2'd3
  } accKind_e;

  typedef struct packed {
    logic load;   // capture a new result
    logic clear;  // result consumed with nothing new
  } segStrobe_t;

endpackage

// File: rtl/segchk_ctrl.sv
module segchk_ctrl
  import segchk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output logic       inReady,
  output logic       outValid,
  input  logic       outReady,
  output segStrobe_t strobe
);

  logic validQ;

  assign inReady      = !validQ || outReady;
  assign strobe.load  = inValid && inReady;
  assign strobe.clear = validQ && outReady && !strobe.load;
  assign outValid     = validQ;

  always_ff @(posedge clk) begin
    if (!rstN)             validQ <= 1'b0;
    else if (strobe.load)  validQ <= 1'b1;
    else if (strobe.clear) validQ <= 1'b0;
  end

  // R1
  accept_then_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);

  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);

endmodule

// File: rtl/segchk_dp.sv
module segchk_dp
  import segchk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LIM_W  = 20,
  parameter int SIZE_W = 2,
  parameter int TYPE_W = 8,
  parameter int NP_VEC = 11,
  parameter int GP_VEC = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  segStrobe_t        strobe,
  input  logic [ADDR_W-1:0] descBase,
  input  logic [LIM_W-1:0]  descLimit,
  input  logic              descGran,
  input  logic              descPresent,
  input  logic [1:0]        descDpl,
  input  logic              descSeg,
  input  logic              descExec,
  input  logic              descDir,
  input  logic              descRw,
  input  logic [ADDR_W-1:0] accOffset,
  input  logic [SIZE_W-1:0] accSize,
  input  logic [1:0]        accKind,
  input  logic [1:0]        accRpl,
  output logic [ADDR_W-1:0] linAddr,
  output logic              fault,
  output logic [TYPE_W-1:0] faultType
);

  localparam int GRAN_SH = ADDR_W - LIM_W;
  localparam int WIDE_W  = ADDR_W + 1;
  localparam logic [TYPE_W-1:0] NP_CODE = TYPE_W'(NP_VEC);
  localparam logic [TYPE_W-1:0] GP_CODE = TYPE_W'(GP_VEC);

  accKind_e           kind;
  logic [ADDR_W-1:0]  effLimit;
  logic [WIDE_W-1:0]  lastByte;
  logic               isDown;
  logic               badBounds;
  logic               badPriv;
  logic               badType;
  logic               anyFault;
  logic [TYPE_W-1:0]  typeNext;
  logic [ADDR_W-1:0]  linNext;

  logic [ADDR_W-1:0]  linQ;
  logic               faultQ;
  logic [TYPE_W-1:0]  typeQ;

  assign kind = accKind_e'(accKind);

  // granularity scaling of the limit
  always_comb begin
    if (descGran) effLimit = {descLimit, {GRAN_SH{1'b1}}};
    else          effLimit = {{GRAN_SH{1'b0}}, descLimit};
  end

  // last byte of the access, one extra bit keeps the carry
  assign lastByte = {1'b0, accOffset} + {{(WIDE_W-SIZE_W){1'b0}}, accSize};
  assign isDown   = !descExec && descDir;

  always_comb begin
    if (isDown)
      badBounds = ({1'b0, accOffset} <= {1'b0, effLimit}) || lastByte[ADDR_W];
    else
      badBounds = lastByte > {1'b0, effLimit};
  end

  assign badPriv = accRpl > descDpl;

  always_comb begin
    badType = 1'b0;
    if (!descSeg) begin
      badType = 1'b1;
    end else begin
      unique case (kind)
        KIND_WRITE: badType = descExec || !descRw;
        KIND_FETCH: badType = !descExec;
        default:    badType = descExec && !descRw;
      endcase
    end
  end

  // ranked selection: not-present, privilege, type, bounds
  always_comb begin
    anyFault = 1'b1;
    typeNext = GP_CODE;
    if (!descPresent)               typeNext = NP_CODE;
    else if (badPriv)               typeNext = GP_CODE;
    else if (badType)               typeNext = GP_CODE;
    else if (badBounds)             typeNext = GP_CODE;
    else begin
      anyFault = 1'b0;
      typeNext = '0;
    end
  end

  assign linNext = descBase + accOffset;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linQ   <= '0;
      faultQ <= 1'b0;
      typeQ  <= '0;
    end else if (strobe.load) begin
      linQ   <= linNext;
      faultQ <= anyFault;
      typeQ  <= typeNext;
    end
  end

  assign linAddr   = linQ;
  assign fault     = faultQ;
  assign faultType = typeQ;

  // R6
  not_present_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !descPresent) |=> (fault && faultType == NP_CODE));

  // R7
  priv_violation_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && descPresent && (accRpl > descDpl)) |=> (fault && faultType == GP_CODE));

  // R9
  fault_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> (faultType == NP_CODE || faultType == GP_CODE));

  // R9
  clean_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fault |-> (faultType == '0));

endmodule

// File: rtl/segAccessCheck.sv
module segAccessCheck
  import segchk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LIM_W  = 20,
  parameter int SIZE_W = 2,
  parameter int TYPE_W = 8,
  parameter int NP_VEC = 11,
  parameter int GP_VEC = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [ADDR_W-1:0] descBase,
  input  logic [LIM_W-1:0]  descLimit,
  input  logic              descGran,
  input  logic              descPresent,
  input  logic [1:0]        descDpl,
  input  logic              descSeg,
  input  logic              descExec,
  input  logic              descDir,
  input  logic              descRw,
  input  logic [ADDR_W-1:0] accOffset,
  input  logic [SIZE_W-1:0] accSize,
  input  logic [1:0]        accKind,
  input  logic [1:0]        accRpl,
  output logic              outValid,
  input  logic              outReady,
  output logic [ADDR_W-1:0] linAddr,
  output logic              fault,
  output logic [TYPE_W-1:0] faultType
);

  segStrobe_t strobe;

  segchk_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inReady  (inReady),
    .outValid (outValid),
    .outReady (outReady),
    .strobe   (strobe)
  );

  segchk_dp #(
    .ADDR_W (ADDR_W),
    .LIM_W  (LIM_W),
    .SIZE_W (SIZE_W),
    .TYPE_W (TYPE_W),
    .NP_VEC (NP_VEC),
    .GP_VEC (GP_VEC)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .descBase    (descBase),
    .descLimit   (descLimit),
    .descGran    (descGran),
    .descPresent (descPresent),
    .descDpl     (descDpl),
    .descSeg     (descSeg),
    .descExec    (descExec),
    .descDir     (descDir),
    .descRw      (descRw),
    .accOffset   (accOffset),
    .accSize     (accSize),
    .accKind     (accKind),
    .accRpl      (accRpl),
    .linAddr     (linAddr),
    .fault       (fault),
    .faultType   (faultType)
  );

  // R1
  result_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> ($stable(linAddr) && $stable(fault) && $stable(faultType)));

endmodule

// File: tb/segAccessCheck_test.sv
`timescale 1ns/1ps
module segAccessCheck_test;

  typedef struct packed {
    logic [31:0] base;
    logic [19:0] lim;
    logic        g;
    logic        p;
    logic [1:0]  dpl;
    logic        s;
    logic        e;
    logic        x;
    logic        rw;
    logic [31:0] off;
    logic [1:0]  sz;
    logic [1:0]  kind;
    logic [1:0]  rpl;
    logic [7:0]  expType;
    logic [31:0] expLin;
  } vec_t;

  localparam int NV = 20;

  // fields: base lim g p dpl s e x rw off sz kind rpl expType expLin
  localparam vec_t VECS [NV] = '{
    // R3 byte limit, last byte inside
    '{32'h10000000, 20'h00001, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h00000001, 2'd0, 2'd0, 2'd0, 8'd0,  32'h10000001},
    // R3 byte limit, one past
    '{32'h10000000, 20'h00001, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h00000002, 2'd0, 2'd0, 2'd0, 8'd13, 32'h10000002},
    // R3 4K granularity, last byte inside
    '{32'h10000000, 20'h00001, 1'b1, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h00001FFF, 2'd0, 2'd0, 2'd0, 8'd0,  32'h10001FFF},
    // R3 4K granularity, one past
    '{32'h10000000, 20'h00001, 1'b1, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h00002000, 2'd0, 2'd0, 2'd0, 8'd13, 32'h10002000},
    // R4 four-byte access ending past limit
    '{32'h00200000, 20'h00100, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h000000FE, 2'd3, 2'd0, 2'd0, 8'd13, 32'h002000FE},
    // R4 four-byte access ending on limit
    '{32'h00200000, 20'h00100, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h000000FD, 2'd3, 2'd0, 2'd0, 8'd0,  32'h002000FD},
    // R4 carry past 2^32 with full limit
    '{32'h00000000, 20'hFFFFF, 1'b1, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 32'hFFFFFFFE, 2'd3, 2'd0, 2'd0, 8'd13, 32'hFFFFFFFE},
    // R5 expand-down, offset equal to limit
    '{32'h00300000, 20'h00FFF, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 32'h00000FFF, 2'd0, 2'd0, 2'd0, 8'd13, 32'h00300FFF},
    // R5 expand-down, write above limit
    '{32'h00300000, 20'h00FFF, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 32'h00001000, 2'd1, 2'd1, 2'd0, 8'd0,  32'h00301000},
    // R5 expand-down, carry past top; R2 address wraps
    '{32'h00300000, 20'h00FFF, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 32'hFFFFFFFE, 2'd3, 2'd0, 2'd0, 8'd13, 32'h002FFFFE},
    // R6 not present outranks privilege
    '{32'h00000000, 20'h00000, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h00000005, 2'd0, 2'd0, 2'd3, 8'd11, 32'h00000005},
    // R7 less privileged requester
    '{32'h00001000, 20'h000FF, 1'b0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h00000010, 2'd0, 2'd0, 2'd2, 8'd13, 32'h00001010},
    // R7 equal level allowed
    '{32'h00001000, 20'h000FF, 1'b0, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 32'h00000010, 2'd0, 2'd0, 2'd2, 8'd0,  32'h00001010},
    // R8 write to read-only data
    '{32'h00001000, 20'h000FF, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h00000010, 2'd0, 2'd1, 2'd0, 8'd13, 32'h00001010},
    // R8 write to readable code
    '{32'h00001000, 20'h000FF, 1'b0, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 32'h00000010, 2'd0, 2'd1, 2'd0, 8'd13, 32'h00001010},
    // R8 read from fetch-only code
    '{32'h00001000, 20'h000FF, 1'b0, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h00000010, 2'd0, 2'd0, 2'd0, 8'd13, 32'h00001010},
    // R8 fetch from fetch-only code
    '{32'h00001000, 20'h000FF, 1'b0, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h00000010, 2'd0, 2'd2, 2'd0, 8'd0,  32'h00001010},
    // R8 fetch from data
    '{32'h00001000, 20'h000FF, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h00000010, 2'd0, 2'd2, 2'd0, 8'd13, 32'h00001010},
    // R8 system descriptor
    '{32'h00001000, 20'h000FF, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h00000010, 2'd0, 2'd0, 2'd0, 8'd13, 32'h00001010},
    // R8 kind 3 read of readable code
    '{32'h00001000, 20'h000FF, 1'b0, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 32'h00000010, 2'd0, 2'd3, 2'd0, 8'd0,  32'h00001010}
  };

  localparam int VREQ [NV] = '{3, 3, 3, 3, 4, 4, 4, 5, 5, 5, 6, 7, 7, 8, 8, 8, 8, 8, 8, 8};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] descBase = '0;
  logic [19:0] descLimit = '0;
  logic        descGran = 1'b0;
  logic        descPresent = 1'b0;
  logic [1:0]  descDpl = '0;
  logic        descSeg = 1'b0;
  logic        descExec = 1'b0;
  logic        descDir = 1'b0;
  logic        descRw = 1'b0;
  logic [31:0] accOffset = '0;
  logic [1:0]  accSize = '0;
  logic [1:0]  accKind = '0;
  logic [1:0]  accRpl = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [31:0] linAddr;
  logic        fault;
  logic [7:0]  faultType;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  segAccessCheck uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .descBase(descBase), .descLimit(descLimit), .descGran(descGran),
    .descPresent(descPresent), .descDpl(descDpl), .descSeg(descSeg),
    .descExec(descExec), .descDir(descDir), .descRw(descRw),
    .accOffset(accOffset), .accSize(accSize), .accKind(accKind), .accRpl(accRpl),
    .outValid(outValid), .outReady(outReady), .linAddr(linAddr),
    .fault(fault), .faultType(faultType)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    descBase = v.base; descLimit = v.lim; descGran = v.g; descPresent = v.p;
    descDpl = v.dpl; descSeg = v.s; descExec = v.e; descDir = v.x; descRw = v.rw;
    accOffset = v.off; accSize = v.sz; accKind = v.kind; accRpl = v.rpl;
  endtask

  task automatic checkResult(input string req, input vec_t v);
    check(req, "outValid", {31'd0, outValid}, 32'd1);
    check(req, "fault", {31'd0, fault}, {31'd0, (v.expType != 8'd0)});
    check(req, "faultType", {24'd0, faultType}, {24'd0, v.expType});
    check("R2", "linAddr", linAddr, v.expLin);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 state during reset
    check("R10", "outValid in reset", {31'd0, outValid}, 32'd0);
    check("R10", "fault in reset", {31'd0, fault}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    // R10 state after reset
    check("R10", "inReady after reset", {31'd0, inReady}, 32'd1);
    check("R10", "outValid after reset", {31'd0, outValid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      inValid = 1'b1;
      @(negedge clk);
      inValid = 1'b0;
      checkResult($sformatf("R%0d", VREQ[i]), VECS[i]);
      // R9 fault flag and code agree
      check("R9", "flag vs code", {31'd0, fault}, {31'd0, (faultType != 8'd0)});
    end

    @(negedge clk);
    // R1 result drops after being taken with nothing new
    check("R1", "outValid after drain", {31'd0, outValid}, 32'd0);

    // R1 stall: result held, competing request not taken
    outReady = 1'b0;
    drive(VECS[0]);
    inValid = 1'b1;
    @(negedge clk);
    drive(VECS[1]);
    repeat (4) @(negedge clk);
    check("R1", "inReady stalled", {31'd0, inReady}, 32'd0);
    checkResult("R1", VECS[0]);
    // R1 release: take result and accept the waiting request in the same edge
    outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    checkResult("R1", VECS[1]);
    @(negedge clk);
    check("R1", "outValid after release", {31'd0, outValid}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule